// File: doc/BRIEF.md
# Disk Controller Interrupt-Status Register Front End

This block is the host-facing register window of a disk controller. A 32-bit host bus makes single-word requests into a 4 KB window. The block byte-reverses every word on its way in and on its way out. It decodes the offset into one register slot per 16 bytes and sends each request to the right target.

Three slots are mapped. The drive data port passes the word through a simple request/acknowledge link to the drive logic. The timing register is 32 bits of plain read/write storage. The interrupt-state register holds a DMA interrupt flag that stays set until software writes a one to clear it, and a one-cycle-delayed copy of the disk interrupt line.

Both raw interrupt inputs also drive their own output pins with no logic in the path. Reads of unmapped slots return all ones. Host requests are taken one at a time: the host raises `host_req` for one cycle and waits for the `host_ack` pulse before it issues the next request.

Top module: `dskc_regfront`

## Requirements
- R1: The slot index is `host_addr[11:4]`, so every byte offset within one 16-byte stride reaches the same slot: index 0x00 is the drive data port, 0x20 is the timing register, 0x30 is the interrupt-state register.
- R2: The internal word is the byte-reversed host word, for writes and for reads alike (host byte 0 becomes internal byte 3).
- R3: A data-port access raises `drv_req` for exactly one cycle. A write presents the byte-reversed word with `drv_we`=1. A read returns the byte-reversed `drv_rdata`. `host_ack` comes one cycle after `drv_ack` and never earlier.
- R4: The timing register returns on read exactly the host word last written to it.
- R5: In the interrupt-state register, the DMA flag is internal bit 31 (host-visible bit 7) and the disk copy is internal bit 30 (host-visible bit 6). Every other bit reads as zero, and writes to those bits have no effect.
- R6: The DMA flag is set on any clock edge at which `dma_irq_in` is high, and it stays set after the input drops.
- R7: A write to the interrupt-state register with host bit 7 set clears the DMA flag. A write with host bit 7 clear leaves the flag unchanged.
- R8: When a set and a clear of the DMA flag fall on the same edge, the flag ends up set.
- R9: The disk bit holds the value of `disk_irq_in` sampled at the previous clock edge.
- R10: `dma_irq_out` equals `dma_irq_in` and `disk_irq_out` equals `disk_irq_in` at all times.
- R11: A read of any unmapped slot returns 0xFFFFFFFF. A write to an unmapped slot changes no register.
- R12: After reset the timing register and both interrupt bits are zero, and `host_ack` and `drv_req` are low.
- R13: A request to a register slot (any slot but the data port) is acknowledged on the edge after the one that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | One-cycle request strobe from the host |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 12 | Byte offset within the window |
| host_wdata | input | 32 | Host write word, host byte order |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read word, host byte order, valid with host_ack |
| drv_req | output | 1 | One-cycle request to the drive data link |
| drv_we | output | 1 | Direction of the drive request |
| drv_wdata | output | 32 | Byte-reversed write word to the drive |
| drv_ack | input | 1 | Drive completion strobe |
| drv_rdata | input | 32 | Drive read word, valid with drv_ack |
| dma_irq_in | input | 1 | DMA interrupt source |
| disk_irq_in | input | 1 | Disk interrupt source level |
| dma_irq_out | output | 1 | Forwarded DMA interrupt |
| disk_irq_out | output | 1 | Forwarded disk interrupt |

## Verification
Words are written with distinct, non-symmetric bytes, so any lane that is mis-swapped or left unswapped shows up at once. The stride is tried at offsets 0x0, 0x4 and 0xC inside a slot, and unmapped reads at slots just beside the mapped ones, which catches a decoder that uses the wrong address bits. The interrupt register is driven four ways: a lone DMA pulse, a write with the wrong bit set, a real clear, and a clear that lands on the same edge as a new DMA pulse. These separate a sticky flag from a level copy, a byte-swapped clear bit from an unswapped one, and set priority from clear priority. The disk line is held and then dropped to show that its copy follows the level.

// File: rtl/dskc_pkg.sv
package dskc_pkg;
  localparam int WORD_W      = 32;
  localparam int WIN_W       = 12;
  localparam int STRIDE_LOG2 = 4;
  localparam int IDX_W       = WIN_W - STRIDE_LOG2;
  localparam int LANES       = WORD_W / 8;

  localparam logic [IDX_W-1:0] IDX_DATA   = IDX_W'(8'h00);
  localparam logic [IDX_W-1:0] IDX_TIMING = IDX_W'(8'h20);
  localparam logic [IDX_W-1:0] IDX_IRQ    = IDX_W'(8'h30);

  localparam int DMA_BIT  = WORD_W - 1;
  localparam int DISK_BIT = WORD_W - 2;

  localparam logic [WORD_W-1:0] UNMAPPED_WORD = '1;

  typedef enum logic [1:0] {SEL_DATA, SEL_TIMING, SEL_IRQ, SEL_NONE} sel_e;
  typedef enum logic {LNK_IDLE, LNK_WAIT} lnk_e;

  // Reverse the byte lanes of one word.
  function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int b = 0; b < LANES; b++) begin
      r[8*b +: 8] = w[8*(LANES-1-b) +: 8];
    end
    return r;
  endfunction

  // Slot number from the byte offset inside the window.
  function automatic logic [IDX_W-1:0] slot_of(input logic [WIN_W-1:0] a);
    return a[WIN_W-1:STRIDE_LOG2];
  endfunction

  // Internal image of the interrupt-state register.
  function automatic logic [WORD_W-1:0] irq_image(input logic dma, input logic disk);
    logic [WORD_W-1:0] r;
    r = '0;
    r[DMA_BIT]  = dma;
    r[DISK_BIT] = disk;
    return r;
  endfunction
endpackage

// File: rtl/dskc_decode.sv
module dskc_decode
  import dskc_pkg::*;
(
  input  logic [WIN_W-1:0] addr,
  output sel_e             sel
);
  logic [IDX_W-1:0] slot;

  always_comb begin
    slot = slot_of(addr);
    unique case (slot)
      IDX_DATA:   sel = SEL_DATA;
      IDX_TIMING: sel = SEL_TIMING;
      IDX_IRQ:    sel = SEL_IRQ;
      default:    sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/dskc_timing_reg.sv
module dskc_timing_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/dskc_irq_state.sv
module dskc_irq_state (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_in,
  input  logic disk_in,
  input  logic wr_hit,
  input  logic wr_clr_bit,
  output logic clr_evt,
  output logic dma_lat,
  output logic disk_q
);
  assign clr_evt = wr_hit & wr_clr_bit;

  // A set on the same edge as a clear wins, so no interrupt is lost.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_lat <= 1'b0;
      disk_q  <= 1'b0;
    end else begin
      dma_lat <= dma_in | (dma_lat & ~clr_evt);
      disk_q  <= disk_in;
    end
  end
endmodule

// File: rtl/dskc_drive_link.sv
module dskc_drive_link
  import dskc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         start_we,
  input  logic [W-1:0] start_wdata,
  input  logic         drv_ack,
  input  logic [W-1:0] drv_rdata,
  output logic         drv_req,
  output logic         drv_we,
  output logic [W-1:0] drv_wdata,
  output logic         busy,
  output logic         in_wait,
  output logic         done,
  output logic [W-1:0] done_rdata
);
  lnk_e st;

  assign in_wait    = (st == LNK_WAIT);
  assign busy       = in_wait;
  assign done       = in_wait & drv_ack;
  assign done_rdata = drv_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= LNK_IDLE;
      drv_req   <= 1'b0;
      drv_we    <= 1'b0;
      drv_wdata <= '0;
    end else begin
      drv_req <= 1'b0;
      unique case (st)
        LNK_IDLE: if (start) begin
          st        <= LNK_WAIT;
          drv_req   <= 1'b1;
          drv_we    <= start_we;
          drv_wdata <= start_wdata;
        end
        LNK_WAIT: if (drv_ack) st <= LNK_IDLE;
        default:  st <= LNK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dskc_regfront.sv
module dskc_regfront
  import dskc_pkg::*;
#(
  parameter int ADDR_W = dskc_pkg::WIN_W,
  parameter int DATA_W = dskc_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ack,
  output logic [DATA_W-1:0] host_rdata,
  output logic              drv_req,
  output logic              drv_we,
  output logic [DATA_W-1:0] drv_wdata,
  input  logic              drv_ack,
  input  logic [DATA_W-1:0] drv_rdata,
  input  logic              dma_irq_in,
  input  logic              disk_irq_in,
  output logic              dma_irq_out,
  output logic              disk_irq_out
);
  sel_e              sel;
  logic              accept;
  logic              reg_hit;
  logic              data_hit;
  logic              lnk_busy;
  logic              lnk_wait;
  logic              lnk_done;
  logic [DATA_W-1:0] lnk_rdata;
  logic [DATA_W-1:0] in_word;
  logic [DATA_W-1:0] timing_q;
  logic              tim_wr;
  logic              irq_wr;
  logic              clr_evt;
  logic              dma_lat;
  logic              disk_q;
  logic [DATA_W-1:0] reg_rd;

  // Raw interrupt lines go straight to their pins.
  assign dma_irq_out  = dma_irq_in;
  assign disk_irq_out = disk_irq_in;

  dskc_decode u_dec (
    .addr (host_addr),
    .sel  (sel)
  );

  assign accept   = host_req & ~lnk_busy;
  assign data_hit = accept & (sel == SEL_DATA);
  assign reg_hit  = accept & (sel != SEL_DATA);
  assign in_word  = swap_bytes(host_wdata);
  assign tim_wr   = reg_hit & host_we & (sel == SEL_TIMING);
  assign irq_wr   = reg_hit & host_we & (sel == SEL_IRQ);

  dskc_timing_reg #(.W(DATA_W)) u_tim (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tim_wr),
    .d     (in_word),
    .q     (timing_q)
  );

  dskc_irq_state u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .dma_in     (dma_irq_in),
    .disk_in    (disk_irq_in),
    .wr_hit     (irq_wr),
    .wr_clr_bit (in_word[DMA_BIT]),
    .clr_evt    (clr_evt),
    .dma_lat    (dma_lat),
    .disk_q     (disk_q)
  );

  dskc_drive_link #(.W(DATA_W)) u_lnk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (data_hit),
    .start_we    (host_we),
    .start_wdata (in_word),
    .drv_ack     (drv_ack),
    .drv_rdata   (drv_rdata),
    .drv_req     (drv_req),
    .drv_we      (drv_we),
    .drv_wdata   (drv_wdata),
    .busy        (lnk_busy),
    .in_wait     (lnk_wait),
    .done        (lnk_done),
    .done_rdata  (lnk_rdata)
  );

  always_comb begin
    unique case (sel)
      SEL_TIMING: reg_rd = timing_q;
      SEL_IRQ:    reg_rd = irq_image(dma_lat, disk_q);
      default:    reg_rd = UNMAPPED_WORD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_ack   <= 1'b0;
      host_rdata <= '0;
    end else begin
      host_ack <= reg_hit | lnk_done;
      if (lnk_done)     host_rdata <= swap_bytes(lnk_rdata);
      else if (reg_hit) host_rdata <= swap_bytes(reg_rd);
    end
  end
endmodule

// File: rtl/dskc_regfront_chk.sv
module dskc_regfront_chk (
  input logic clk,
  input logic rst_n,
  input logic dma_irq_in,
  input logic disk_irq_in,
  input logic dma_lat,
  input logic disk_q,
  input logic clr_evt,
  input logic reg_hit,
  input logic drv_req,
  input logic lnk_wait,
  input logic drv_ack,
  input logic host_ack
);
  a_r6_dma_set: assert property (@(posedge clk) disable iff (!rst_n)
    dma_irq_in |=> dma_lat);

  a_r7_dma_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !dma_irq_in) |=> !dma_lat);

  a_r7_dma_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_evt && !dma_irq_in) |=> $stable(dma_lat));

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && dma_irq_in) |=> dma_lat);

  a_r9_disk_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(disk_irq_in) |=> (disk_q == $past(disk_irq_in)));

  a_r3_drv_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    drv_req |=> !drv_req);

  a_r3_ack_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_wait && !drv_ack) |=> !host_ack);

  a_r13_reg_ack: assert property (@(posedge clk) disable iff (!rst_n)
    reg_hit |=> host_ack);
endmodule

bind dskc_regfront dskc_regfront_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dma_irq_in  (dma_irq_in),
  .disk_irq_in (disk_irq_in),
  .dma_lat     (dma_lat),
  .disk_q      (disk_q),
  .clr_evt     (clr_evt),
  .reg_hit     (reg_hit),
  .drv_req     (drv_req),
  .lnk_wait    (lnk_wait),
  .drv_ack     (drv_ack),
  .host_ack    (host_ack)
);

// File: tb/sim_dskc_regfront.sv
module sim_dskc_regfront;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        host_ack;
  logic [31:0] host_rdata;
  logic        drv_req;
  logic        drv_we;
  logic [31:0] drv_wdata;
  logic        drv_ack = 1'b0;
  logic [31:0] drv_rdata = '0;
  logic        dma_irq_in = 1'b0;
  logic        disk_irq_in = 1'b0;
  logic        dma_irq_out;
  logic        disk_irq_out;

  int          n_chk = 0;
  int          n_fail = 0;
  logic [31:0] rsp_word = 32'h0;
  logic        seen_we = 1'b0;
  logic [31:0] seen_wdata = 32'h0;
  int          drv_cnt = 0;

  always #10 clk = ~clk;

  dskc_regfront u0 (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
    .drv_req(drv_req), .drv_we(drv_we), .drv_wdata(drv_wdata),
    .drv_ack(drv_ack), .drv_rdata(drv_rdata),
    .dma_irq_in(dma_irq_in), .disk_irq_in(disk_irq_in),
    .dma_irq_out(dma_irq_out), .disk_irq_out(disk_irq_out)
  );

  // Table: write flag, offset, host word, expected host read word.
  localparam int NV = 9;
  localparam logic [76:0] VECS [NV] = '{
    {1'b1, 12'h200, 32'h1122_3344, 32'h0},          // R4 store
    {1'b0, 12'h200, 32'h0,         32'h1122_3344},  // R4 R2 read back
    {1'b0, 12'h204, 32'h0,         32'h1122_3344},  // R1 same slot
    {1'b0, 12'h100, 32'h0,         32'hFFFF_FFFF},  // R11 unmapped
    {1'b0, 12'h310, 32'h0,         32'hFFFF_FFFF},  // R11 next to irq slot
    {1'b0, 12'h210, 32'h0,         32'hFFFF_FFFF},  // R11 next to timing slot
    {1'b0, 12'h300, 32'h0,         32'h0000_0000},  // R5 idle status
    {1'b1, 12'h20C, 32'hA5C3_0F81, 32'h0},          // R1 R4 top of stride
    {1'b0, 12'h200, 32'h0,         32'hA5C3_0F81}   // R4 new value
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_xfer(input logic we, input logic [11:0] a, input logic [31:0] d,
                           output logic [31:0] rd, output int lat);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0;
    lat = 1;
    while (!host_ack && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    rd = host_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] rd; int lat;
    host_xfer(1'b1, a, d, rd, lat);
  endtask

  task automatic rdchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] rd; int lat;
    host_xfer(1'b0, a, 32'h0, rd, lat);
    chk(tag, rd, exp);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  // Drive side model: acknowledge one cycle after seeing a request.
  initial begin
    forever begin
      @(negedge clk);
      if (drv_req) begin
        seen_we = drv_we;
        seen_wdata = drv_wdata;
        drv_cnt++;
        @(negedge clk);
        drv_ack = 1'b1;
        drv_rdata = rsp_word;
        @(negedge clk);
        drv_ack = 1'b0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int lat;
    repeat (3) @(negedge clk);
    chk("R12 ack low in reset", {31'b0, host_ack}, 32'h0);
    chk("R12 drv_req low in reset", {31'b0, drv_req}, 32'h0);
    rst_n = 1'b1;
    rdchk("R12 timing after reset", 12'h200, 32'h0);
    rdchk("R12 status after reset", 12'h300, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i][76]) wr(VECS[i][75:64], VECS[i][63:32]);
      else rdchk($sformatf("R1 R4 R11 vector %0d", i), VECS[i][75:64], VECS[i][31:0]);
    end

    // R11: writes to an unmapped slot touch nothing
    wr(12'h100, 32'hDEAD_BEEF);
    rdchk("R11 timing untouched", 12'h200, 32'hA5C3_0F81);
    rdchk("R11 status untouched", 12'h300, 32'h0);

    // R13: register read answered one cycle after acceptance
    host_xfer(1'b0, 12'h200, 32'h0, rd, lat);
    chk("R13 register latency", lat, 1);

    // R2 R3: data port write, byte swapped toward the drive
    host_xfer(1'b1, 12'h004, 32'h0102_0304, rd, lat);
    chk("R3 drive request count", drv_cnt, 1);
    chk("R3 drive write flag", {31'b0, seen_we}, 32'h1);
    chk("R2 drive write word", seen_wdata, 32'h0403_0201);
    // R2 R3: data port read, swapped back, ack after drv_ack
    rsp_word = 32'hAABB_CCDD;
    host_xfer(1'b0, 12'h008, 32'h0, rd, lat);
    chk("R2 drive read word", rd, 32'hDDCC_BBAA);
    chk("R3 drive read flag", {31'b0, seen_we}, 32'h0);
    chk("R3 ack after drive ack", lat, 3);

    // R10: forwarding is immediate
    @(negedge clk); dma_irq_in = 1'b1; #1;
    chk("R10 dma forwarded", {30'b0, dma_irq_out, disk_irq_out}, 32'h2);
    @(negedge clk); dma_irq_in = 1'b0; #1;
    chk("R10 dma released", {31'b0, dma_irq_out}, 32'h0);

    // R6: the pulse above stays latched
    rdchk("R6 dma latched", 12'h300, 32'h0000_0080);
    // R7 R5: unswapped top bit does not clear
    wr(12'h300, 32'h8000_0000);
    rdchk("R7 wrong lane keeps flag", 12'h300, 32'h0000_0080);
    wr(12'h300, 32'h0000_0080);
    rdchk("R7 clear", 12'h300, 32'h0);

    // R8: set and clear on the same edge
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = 12'h300; host_wdata = 32'h0000_0080;
    dma_irq_in = 1'b1;
    @(negedge clk);
    host_req = 1'b0; dma_irq_in = 1'b0;
    @(negedge clk);
    rdchk("R8 set wins over clear", 12'h300, 32'h0000_0080);
    wr(12'h300, 32'h0000_0080);

    // R9 R10: disk level copy
    @(negedge clk); disk_irq_in = 1'b1; #1;
    chk("R10 disk forwarded", {31'b0, disk_irq_out}, 32'h1);
    repeat (2) @(negedge clk);
    rdchk("R9 disk high", 12'h300, 32'h0000_0040);
    @(negedge clk); disk_irq_in = 1'b0;
    repeat (2) @(negedge clk);
    rdchk("R9 disk low", 12'h300, 32'h0);

    finish_run();
  end
endmodule